// File: doc/BRIEF.md
# Serial Audio Sample FIFO Pair

This block holds samples between a bus-side agent (processor or DMA engine) and a serial audio shifter. It has two queues, and neither depends on the other. The transmit queue is loaded by bus writes and drained by the shifter. The receive queue is loaded by the shifter and drained by bus reads. Each queue has a threshold and an enable, and from them drives a level request that an interrupt controller or a DMA engine can use to decide when to service the queue. Status outputs give the fill level and the full and empty flags of both queues. Two sticky error flags record a receive sample lost to a full queue and a transmit slot the shifter found empty.

Samples are right-justified. The programmed sample size decides which low-order bits are meaningful. Bits above that size are cleared before a sample reaches the shifter, and cleared before a received sample is stored, so the bus agent may leave them undefined. A bus read of an empty receive queue returns the last value read and leaves the queue as it was. Turning the port off empties both queues and zeroes the held read value.

Top module: `audio_fifo_pair`

## Requirements
- R1: Each queue is first-in first-out with DEPTH (16) entries. Its count, full and empty outputs change on the clock edge that accepts a push or a pop. Activity on one queue never changes the other.
- R2: `rx_req` is high exactly when `cfg_rx_ie` is 1 and `rx_count` is strictly greater than `cfg_rx_thr`.
- R3: `tx_req` is high exactly when `cfg_tx_ie` is 1 and `tx_count` is at most `cfg_tx_thr` + 1. This includes `cfg_tx_thr` = 15, where a full queue still requests.
- R4: While the receive queue is empty, `bus_rdata` shows the value returned by the last accepted read. Asserting `bus_rd_en` then leaves the count and that value unchanged.
- R5: The sample size is `cfg_dsize_m1` + 1 bits, and any value below 4 is treated as 4. Bits at or above the size read as 0 on `ser_tx_data`, and are stored as 0 for received samples.
- R6: A `ser_rx_valid` pulse while the receive queue is full, with no read in the same cycle, drops the sample and sets `rx_overrun`. The flag stays set until a cycle with `clr_rx_overrun` = 1 and no new overrun; a new overrun in that cycle wins.
- R7: `ser_tx_req` while the transmit queue is empty presents the last sample popped on `ser_tx_data` and sets the sticky `tx_underrun`. That flag is cleared by `clr_tx_underrun` in the same way R6 clears `rx_overrun`.
- R8: With `cfg_enable` = 0, both queues are empty from the next edge on, the held read value becomes 0, and pushes and pops are ignored.
- R9: A push and a pop accepted in the same cycle leave the count unchanged and lose no sample. This holds for a full receive queue, where the push is then accepted without overrun.
- R10: A bus write to a full transmit queue with no pop in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port on; 0 flushes both queues |
| cfg_dsize_m1 | input | 5 | Sample size minus one |
| cfg_rx_thr | input | 4 | Receive threshold |
| cfg_tx_thr | input | 4 | Transmit threshold |
| cfg_rx_ie | input | 1 | Receive request enable |
| cfg_tx_ie | input | 1 | Transmit request enable |
| bus_wr_en | input | 1 | Bus write to transmit queue |
| bus_wdata | input | 32 | Bus write sample |
| bus_rd_en | input | 1 | Bus read from receive queue |
| bus_rdata | output | 32 | Receive head, or held value when empty |
| ser_tx_req | input | 1 | Shifter takes a transmit sample |
| ser_tx_data | output | 32 | Masked transmit sample |
| ser_rx_valid | input | 1 | Shifter delivers a receive sample |
| ser_rx_data | input | 32 | Received sample |
| clr_rx_overrun | input | 1 | Write-one clear of overrun flag |
| clr_tx_underrun | input | 1 | Write-one clear of underrun flag |
| tx_count | output | 5 | Transmit fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_count | output | 5 | Receive fill level |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_underrun | output | 1 | Sticky transmit underrun |

## Verification
A pointer or count that drifts shows up on the status outputs one edge after the push or pop that caused it. Because the requests are combinational on the count, it also shows up on the requests in that same cycle. Data-path corruption is only seen when the affected entry reaches the head, so the tests drain each queue completely and compare every sample in order. A stale or uncleared holding register shows up on the next read of an empty receive queue, or on the next starved shifter request.

// File: rtl/afp_pkg.sv
package afp_pkg;

  // Effective sample width: programmed value plus one, clamped into [4, dw].
  function automatic int unsigned eff_size(input int unsigned m1, input int unsigned dw);
    int unsigned v;
    v = m1 + 1;
    if (v < 4) v = 4;
    if (v > dw) v = dw;
    return v;
  endfunction

  // Receive service: more entries than the threshold.
  function automatic logic rx_fire(input int unsigned cnt, input int unsigned thr, input logic ie);
    return ie && (cnt > thr);
  endfunction

  // Transmit service: entries not above threshold plus one.
  function automatic logic tx_fire(input int unsigned cnt, input int unsigned thr, input logic ie);
    return ie && (cnt <= thr + 1);
  endfunction

endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/afp_sticky.sv
module afp_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import afp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THW   = 4,
  localparam int unsigned SZW  = $clog2(DW),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_enable,
  input  logic [SZW-1:0] cfg_dsize_m1,
  input  logic [THW-1:0] cfg_rx_thr,
  input  logic [THW-1:0] cfg_tx_thr,
  input  logic           cfg_rx_ie,
  input  logic           cfg_tx_ie,
  input  logic           bus_wr_en,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_rd_en,
  output logic [DW-1:0]  bus_rdata,
  input  logic           ser_tx_req,
  output logic [DW-1:0]  ser_tx_data,
  input  logic           ser_rx_valid,
  input  logic [DW-1:0]  ser_rx_data,
  input  logic           clr_rx_overrun,
  input  logic           clr_tx_underrun,
  output logic [CW-1:0]  tx_count,
  output logic           tx_full,
  output logic           tx_empty,
  output logic [CW-1:0]  rx_count,
  output logic           rx_full,
  output logic           rx_empty,
  output logic           tx_req,
  output logic           rx_req,
  output logic           rx_overrun,
  output logic           tx_underrun
);

  // Named internal events (observed by the bound checker)
  logic          flush;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          rx_drop, tx_starve;
  logic [DW-1:0] size_mask;
  logic [DW-1:0] tx_head, rx_head;
  logic [DW-1:0] tx_last, rx_last;

  assign flush = !cfg_enable;

  // Right-justification mask from the programmed size
  always_comb begin
    int unsigned w;
    w = eff_size(int'(cfg_dsize_m1), DW);
    for (int b = 0; b < int'(DW); b++) size_mask[b] = (b < int'(w));
  end

  afp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(bus_wr_en), .din(bus_wdata), .pop(ser_tx_req),
    .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  afp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(ser_rx_valid), .din(ser_rx_data & size_mask), .pop(bus_rd_en),
    .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  // Hold registers: last sample sent and last sample read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_last <= '0;
      rx_last <= '0;
    end else if (flush) begin
      tx_last <= '0;
      rx_last <= '0;
    end else begin
      if (tx_pop_ok) tx_last <= tx_head & size_mask;
      if (rx_pop_ok) rx_last <= rx_head;
    end
  end

  assign ser_tx_data = tx_empty ? tx_last : (tx_head & size_mask);
  assign bus_rdata   = rx_empty ? rx_last : rx_head;

  // Error events
  assign rx_drop   = ser_rx_valid && cfg_enable && rx_full && !rx_pop_ok;
  assign tx_starve = ser_tx_req && cfg_enable && tx_empty;

  afp_sticky u_ror (.clk(clk), .rst_n(rst_n), .set(rx_drop),   .clr(clr_rx_overrun),  .q(rx_overrun));
  afp_sticky u_tur (.clk(clk), .rst_n(rst_n), .set(tx_starve), .clr(clr_tx_underrun), .q(tx_underrun));

  // Level requests from current counts
  assign rx_req = rx_fire(int'(rx_count), int'(cfg_rx_thr), cfg_rx_ie);
  assign tx_req = tx_fire(int'(tx_count), int'(cfg_tx_thr), cfg_tx_ie);

endmodule

// File: rtl/afp_checker.sv
module afp_checker #(
  parameter int unsigned DW  = 32,
  parameter int unsigned THW = 4,
  parameter int unsigned CW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_enable,
  input logic           cfg_rx_ie,
  input logic [THW-1:0] cfg_rx_thr,
  input logic [THW-1:0] cfg_tx_thr,
  input logic           ser_rx_valid,
  input logic           clr_rx_overrun,
  input logic [DW-1:0]  bus_rdata,
  input logic           bus_rd_en,
  input logic [CW-1:0]  tx_count,
  input logic [CW-1:0]  rx_count,
  input logic           rx_full,
  input logic           rx_empty,
  input logic           tx_full,
  input logic           tx_empty,
  input logic           rx_req,
  input logic           tx_req,
  input logic           rx_overrun,
  input logic           tx_underrun,
  input logic           tx_push_ok,
  input logic           tx_pop_ok,
  input logic           rx_push_ok,
  input logic           rx_pop_ok,
  input logic           rx_drop,
  input logic           tx_starve
);

  AST_TX_ONE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_ok && !tx_pop_ok |=> tx_count == $past(tx_count) + 1);  // R1
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty) && !(tx_full && tx_empty));  // R1
  AST_RX_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> cfg_rx_ie && (rx_count > cfg_rx_thr));  // R2
  AST_TX_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> ({1'b0, tx_count} <= {2'b00, cfg_tx_thr} + 6'd1));  // R3
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en && rx_empty && !ser_rx_valid && cfg_enable |=> rx_empty && $stable(bus_rdata));  // R4
  AST_ROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !clr_rx_overrun |=> rx_overrun);  // R6
  AST_DROP_SETS_ROR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> rx_overrun && $stable(rx_count));  // R6
  AST_STARVE_SETS_TUR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_starve |=> tx_underrun && tx_empty);  // R7
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> tx_empty && rx_empty);  // R8
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_ok && rx_pop_ok && bus_rd_en |=> $stable(rx_count));  // R9
  AST_TX_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_pop_ok |=> tx_count == $past(tx_count));  // R10

endmodule

bind audio_fifo_pair afp_checker #(.DW(DW), .THW(THW), .CW(CW)) u_afp_checker (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rx_ie(cfg_rx_ie),
  .cfg_rx_thr(cfg_rx_thr), .cfg_tx_thr(cfg_tx_thr), .ser_rx_valid(ser_rx_valid),
  .clr_rx_overrun(clr_rx_overrun), .bus_rdata(bus_rdata), .bus_rd_en(bus_rd_en),
  .tx_count(tx_count), .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_req(rx_req), .tx_req(tx_req),
  .rx_overrun(rx_overrun), .tx_underrun(tx_underrun),
  .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok), .rx_push_ok(rx_push_ok),
  .rx_pop_ok(rx_pop_ok), .rx_drop(rx_drop), .tx_starve(tx_starve)
);

// File: tb/test_audio_fifo_pair.sv
module test_audio_fifo_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_rx_ie = 1'b0, cfg_tx_ie = 1'b0;
  logic [4:0]  cfg_dsize_m1 = 5'd31;
  logic [3:0]  cfg_rx_thr = '0, cfg_tx_thr = '0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0, ser_tx_req = 1'b0, ser_rx_valid = 1'b0;
  logic [31:0] bus_wdata = '0, ser_rx_data = '0;
  logic        clr_rx_overrun = 1'b0, clr_tx_underrun = 1'b0;
  logic [31:0] bus_rdata, ser_tx_data;
  logic [4:0]  tx_count, rx_count;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_req, rx_req, rx_overrun, tx_underrun;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_fifo_pair i_audio_fifo_pair (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dsize_m1(cfg_dsize_m1),
    .cfg_rx_thr(cfg_rx_thr), .cfg_tx_thr(cfg_tx_thr), .cfg_rx_ie(cfg_rx_ie), .cfg_tx_ie(cfg_tx_ie),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .ser_tx_req(ser_tx_req), .ser_tx_data(ser_tx_data), .ser_rx_valid(ser_rx_valid),
    .ser_rx_data(ser_rx_data), .clr_rx_overrun(clr_rx_overrun), .clr_tx_underrun(clr_tx_underrun),
    .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .rx_count(rx_count),
    .rx_full(rx_full), .rx_empty(rx_empty), .tx_req(tx_req), .rx_req(rx_req),
    .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ser_push(input logic [31:0] d);
    @(negedge clk); ser_rx_valid = 1'b1; ser_rx_data = d;
    @(posedge clk); #1; ser_rx_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_wdata = d;
    @(posedge clk); #1; bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1; bus_rd_en = 1'b0;
  endtask

  task automatic ser_pop(output logic [31:0] d);
    @(negedge clk); ser_tx_req = 1'b1; #1 d = ser_tx_data;
    @(posedge clk); #1; ser_tx_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "reset tx_count", tx_count, 0);
    chk("R1", "reset rx_count", rx_count, 0);
    chk("R1", "reset empties", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk("R6", "reset flags", {rx_overrun, tx_underrun}, 0);
    chk("R4", "reset rdata", bus_rdata, 0);
  endtask

  task automatic t_order;
    logic [31:0] d;
    bus_wr(32'hA1); bus_wr(32'hB2); bus_wr(32'hC3);
    chk("R1", "tx_count after 3", tx_count, 3);
    chk("R1", "rx untouched", rx_count, 0);
    ser_push(32'h11); ser_push(32'h22);
    chk("R1", "rx_count after 2", rx_count, 2);
    chk("R1", "tx untouched", tx_count, 3);
    ser_pop(d); chk("R1", "tx order 0", d, 32'hA1);
    ser_pop(d); chk("R1", "tx order 1", d, 32'hB2);
    ser_pop(d); chk("R1", "tx order 2", d, 32'hC3);
    chk("R1", "tx empty", tx_empty, 1);
    bus_rd(d); chk("R1", "rx order 0", d, 32'h11);
    bus_rd(d); chk("R1", "rx order 1", d, 32'h22);
  endtask

  task automatic t_rx_thr;
    logic [31:0] d;
    cfg_rx_thr = 4'd5; cfg_rx_ie = 1'b1;
    for (int i = 0; i < 5; i++) ser_push(32'h40 + i);
    chk("R2", "count=thr no req", rx_req, 0);
    ser_push(32'h45);
    chk("R2", "count>thr req", rx_req, 1);
    cfg_rx_ie = 1'b0; #1;
    chk("R2", "ie off masks req", rx_req, 0);
    cfg_rx_ie = 1'b1;
    bus_rd(d);
    chk("R2", "back to thr no req", rx_req, 0);
    for (int i = 0; i < 5; i++) bus_rd(d);
    cfg_rx_ie = 1'b0; cfg_rx_thr = '0;
  endtask

  task automatic t_tx_thr;
    logic [31:0] d;
    cfg_tx_thr = 4'd3; cfg_tx_ie = 1'b1; #1;
    chk("R3", "empty requests", tx_req, 1);
    for (int i = 0; i < 4; i++) bus_wr(32'h60 + i);
    chk("R3", "count=thr+1 req", tx_req, 1);
    bus_wr(32'h64);
    chk("R3", "count=thr+2 no req", tx_req, 0);
    ser_pop(d);
    chk("R3", "back to thr+1 req", tx_req, 1);
    for (int i = 0; i < 4; i++) ser_pop(d);
    cfg_tx_ie = 1'b0; cfg_tx_thr = '0;
  endtask

  task automatic t_empty_read;
    logic [31:0] d;
    ser_push(32'h5A5A);
    bus_rd(d); chk("R4", "normal read", d, 32'h5A5A);
    bus_rd(d); chk("R4", "empty read repeats", d, 32'h5A5A);
    chk("R4", "empty read count", rx_count, 0);
    bus_rd(d); chk("R4", "second empty read", d, 32'h5A5A);
    ser_push(32'h66);
    chk("R4", "count after push", rx_count, 1);
    bus_rd(d); chk("R4", "read after empty reads", d, 32'h66);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    cfg_dsize_m1 = 5'd7;
    bus_wr(32'hFFFF_FFA5); ser_pop(d); chk("R5", "tx 8-bit", d, 32'hA5);
    ser_push(32'h1234); bus_rd(d); chk("R5", "rx 8-bit", d, 32'h34);
    cfg_dsize_m1 = 5'd1;
    bus_wr(32'hFF); ser_pop(d); chk("R5", "size clamp to 4", d, 32'hF);
    cfg_dsize_m1 = 5'd31;
    bus_wr(32'hFFFF_FFFF); ser_pop(d); chk("R5", "tx 32-bit", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    int bad = 0;
    for (int i = 0; i < 16; i++) ser_push(32'h100 + i);
    chk("R6", "full before overrun", {rx_full, rx_overrun}, 2'b10);
    ser_push(32'hDEAD);
    chk("R6", "overrun flag", rx_overrun, 1);
    chk("R6", "count stays 16", rx_count, 16);
    @(negedge clk);
    chk("R6", "flag sticky", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      bus_rd(d);
      if (d !== 32'h100 + i) bad++;
    end
    chk("R6", "drain mismatches", bad, 0);
    bus_rd(d); chk("R6", "dropped sample absent", d, 32'h10F);
    @(negedge clk); clr_rx_overrun = 1'b1; @(posedge clk); #1; clr_rx_overrun = 1'b0;
    chk("R6", "clear", rx_overrun, 0);
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    bus_wr(32'h77); ser_pop(d); chk("R7", "pop", d, 32'h77);
    chk("R7", "no underrun yet", tx_underrun, 0);
    ser_pop(d); chk("R7", "starved data repeats", d, 32'h77);
    chk("R7", "underrun set", tx_underrun, 1);
    chk("R7", "count stays 0", tx_count, 0);
    @(negedge clk);
    chk("R7", "sticky", tx_underrun, 1);
    @(negedge clk); clr_tx_underrun = 1'b1; @(posedge clk); #1; clr_tx_underrun = 1'b0;
    chk("R7", "clear", tx_underrun, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    ser_push(32'h31); ser_push(32'h32); bus_rd(d);
    bus_wr(32'h81); bus_wr(32'h82);
    @(negedge clk); cfg_enable = 1'b0; @(posedge clk); #1;
    chk("R8", "counts flushed", {tx_count, rx_count}, 0);
    chk("R8", "empties", {tx_empty, rx_empty}, 2'b11);
    chk("R8", "hold cleared", bus_rdata, 0);
    ser_push(32'h99); bus_wr(32'h98);
    chk("R8", "pushes ignored", {tx_count, rx_count}, 0);
    @(negedge clk); cfg_enable = 1'b1;
    bus_rd(d); chk("R8", "empty read after flush", d, 0);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    int bad = 0;
    ser_push(32'h41); ser_push(32'h42);
    @(negedge clk); ser_rx_valid = 1'b1; ser_rx_data = 32'h43; bus_rd_en = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1; ser_rx_valid = 1'b0; bus_rd_en = 1'b0;
    chk("R9", "rx swap head", d, 32'h41);
    chk("R9", "rx swap count", rx_count, 2);
    bus_rd(d); chk("R9", "rx after swap 0", d, 32'h42);
    bus_rd(d); chk("R9", "rx after swap 1", d, 32'h43);
    bus_wr(32'h51);
    @(negedge clk); bus_wr_en = 1'b1; bus_wdata = 32'h52; ser_tx_req = 1'b1; #1 d = ser_tx_data;
    @(posedge clk); #1; bus_wr_en = 1'b0; ser_tx_req = 1'b0;
    chk("R9", "tx swap head", d, 32'h51);
    chk("R9", "tx swap count", tx_count, 1);
    ser_pop(d); chk("R9", "tx after swap", d, 32'h52);
    for (int i = 0; i < 16; i++) ser_push(32'h200 + i);
    @(negedge clk); ser_rx_valid = 1'b1; ser_rx_data = 32'h2FF; bus_rd_en = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1; ser_rx_valid = 1'b0; bus_rd_en = 1'b0;
    chk("R9", "full swap head", d, 32'h200);
    chk("R9", "full swap count/ror", {rx_count, rx_overrun}, {5'd16, 1'b0});
    for (int i = 1; i < 16; i++) begin
      bus_rd(d);
      if (d !== 32'h200 + i) bad++;
    end
    chk("R9", "full swap drain", bad, 0);
    bus_rd(d); chk("R9", "full swap newest kept", d, 32'h2FF);
  endtask

  task automatic t_tx_full;
    logic [31:0] d;
    int bad = 0;
    cfg_tx_thr = 4'd15; cfg_tx_ie = 1'b1;
    for (int i = 0; i < 16; i++) bus_wr(32'h300 + i);
    chk("R10", "full flag", tx_full, 1);
    chk("R3", "thr 15 full still requests", tx_req, 1);
    bus_wr(32'hBAD);
    chk("R10", "count stays 16", tx_count, 16);
    for (int i = 0; i < 16; i++) begin
      ser_pop(d);
      if (d !== 32'h300 + i) bad++;
    end
    chk("R10", "drain no extra", bad, 0);
    chk("R10", "empty after drain", {tx_empty, tx_underrun}, 2'b10);
    cfg_tx_ie = 1'b0; cfg_tx_thr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_enable = 1'b1;
    t_order();
    t_rx_thr();
    t_tx_thr();
    t_empty_read();
    t_mask();
    t_overrun();
    t_underrun();
    t_disable();
    t_simul();
    t_tx_full();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule